// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts hardware events for profiling. Four 32-bit counters run side by side. Each counter picks one line out of a 256-line vector of single-cycle event strobes. It picks that line using its own 8-bit code, and the four codes share one select register. One global run bit starts and stops all counting. When a counter wraps past its all-ones value, it sets a sticky overflow flag. Each flag has its own interrupt-enable bit, and together they drive one level interrupt request.

Software reaches every control word and every counter through a simple register port. Writes take effect at the clock edge. Reads are combinational. Code 0xFF parks a counter so that it ignores all events. After reset every counter is parked and the unit is halted.

The global run state is a two-state machine, `ST_HALT` and `ST_RUN`:
- A control write with bit 0 set takes `ST_HALT` to `ST_RUN` (transition "start").
- A control write with bit 0 clear takes `ST_RUN` to `ST_HALT` (transition "stop").
- Any other cycle keeps the current state (transition "hold").

Each counter slice also decodes a per-cycle mode:
- `CS_STOPPED` when the unit is halted.
- `CS_PARKED` when its code is 0xFF.
- `CS_ARMED` otherwise.

Top module: `event_perf_monitor`

Register addresses on `reg_addr`:

| Address | Contents |
|---------|----------|
| 0 | Control; bit 0 is the run bit |
| 1 | Interrupt enables, bits 3:0 |
| 2 | Overflow flags, bits 3:0, write-one-to-clear |
| 3 | Event select |
| 4 to 7 | Counters 0 to 3 |

## Requirements
- R1: Counter k (k = 0..3) counts the strobe line whose index is held in event-select bits 8k+7:8k. Counter k is read and written at address 4+k. The event-select register is at address 3. A strobe on any other line leaves counter k unchanged.
- R2: While running, a counter whose selected strobe is high at a rising edge increments by exactly one at that edge.
- R3: A counter incremented from 0xFFFF_FFFF becomes 0 and sets its overflow flag (bit k of address 2). It then keeps counting from 0.
- R4: `irq` is high exactly when some counter has both its overflow flag and its enable bit (bit k of address 1) set. Clearing the run bit does not lower `irq`. Clearing the enable bit lowers it while the flag stays set.
- R5: A counter whose select code is 0xFF holds its value whatever the strobes do.
- R6: While halted, no counter changes on strobes. Register reads and writes still work.
- R7: Writing a one to bit k of address 2 clears flag k. Writing a zero leaves it unchanged.
- R8: A register write to a counter in the same cycle as a counted event loads the written value, and the event is lost.
- R9: An overflow in the same cycle as a clear of the same flag leaves the flag set.
- R10: After reset the unit is halted and all flags and enables are 0. All counters read 0 and event select reads 0xFFFF_FFFF.
- R11: A write to address 0 loads the run bit from data bit 0. Address 0 reads back the run bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_strobe | input | 256 | Single-cycle event strobes, one per event code |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `reg_wr`, `reg_addr` and `evt_strobe` are valid at every rising edge after reset. They also assume that software changes event codes only while the unit is halted, so each flag rule can be tied to one counter's own strobe in one cycle. The bench keeps to this:
- It changes inputs only on falling edges.
- It holds the strobes at zero during every register write, except in the two collision tests, where it drives the write and the strobe together on purpose.
- It rewrites event select only after stopping the unit.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int NUM_CNT   = 4;
    localparam int CNT_W     = 32;
    localparam int SEL_W     = 8;
    localparam int NUM_EVT   = 1 << SEL_W;
    localparam int ADDR_W    = 3;
    localparam logic [SEL_W-1:0] PARK_CODE = '1;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_INTEN = 3'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd2;
    localparam logic [ADDR_W-1:0] A_EVSEL = 3'd3;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef enum logic [1:0] {
        CS_STOPPED = 2'd0,
        CS_PARKED  = 2'd1,
        CS_ARMED   = 2'd2
    } slice_mode_t;
endpackage

// File: rtl/pmu_run_fsm.sv
module pmu_run_fsm
    import pmu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_bit,
    output logic run
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctrl_wr && ctrl_bit)  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !ctrl_bit) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        run = (state_q == ST_RUN);
    end

    a_r11_ctrl_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (run == $past(ctrl_bit)));
endmodule

// File: rtl/pmu_counter_slice.sv
module pmu_counter_slice
    import pmu_pkg::*;
#(
    parameter int W     = CNT_W,
    parameter int SW    = SEL_W,
    parameter int NEVT  = NUM_EVT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [SW-1:0]   sel,
    input  logic [NEVT-1:0] evt_vec,
    input  logic            cnt_wr,
    input  logic [W-1:0]    wdata,
    input  logic            flag_clr,
    output logic [W-1:0]    count,
    output logic            flag
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [SW-1:0] PARK    = '1;

    slice_mode_t mode;
    logic        hit;
    logic        wrap;

    always_comb begin
        if (!run)             mode = CS_STOPPED;
        else if (sel == PARK) mode = CS_PARKED;
        else                  mode = CS_ARMED;
    end

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            CS_STOPPED: hit = 1'b0;
            CS_PARKED:  hit = 1'b0;
            CS_ARMED:   hit = evt_vec[sel];
            default:    hit = 1'b0;
        endcase
        wrap = hit && !cnt_wr && (count == ALL_ONES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (cnt_wr) count <= wdata;
        else if (hit)    count <= count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sel != PARK && evt_vec[sel] && !cnt_wr && count == ALL_ONES)
        |=> (flag && count == '0));
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sel != PARK && evt_vec[sel] && !cnt_wr)
        |=> (count == $past(count) + 1'b1));
    a_r5_parked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PARK && !cnt_wr) |=> $stable(count));
    a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count));
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wdata)));
    a_r9_overflow_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && run && sel != PARK && evt_vec[sel] && !cnt_wr && count == ALL_ONES)
        |=> flag);
endmodule

// File: rtl/event_perf_monitor.sv
module event_perf_monitor
    import pmu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [CNT_W-1:0]    reg_wdata,
    output logic [CNT_W-1:0]    reg_rdata,
    input  logic [NUM_EVT-1:0]  evt_strobe,
    output logic                irq
);
    localparam int EVSEL_W = NUM_CNT * SEL_W;

    logic                      run;
    logic [NUM_CNT-1:0]        inten_q;
    logic [EVSEL_W-1:0]        evsel_q;
    logic [NUM_CNT-1:0]        flags;
    logic [CNT_W-1:0]          counts [NUM_CNT];
    logic                      wr_ctrl, wr_inten, wr_flags, wr_evsel;

    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
        wr_inten = reg_wr && (reg_addr == A_INTEN);
        wr_flags = reg_wr && (reg_addr == A_FLAGS);
        wr_evsel = reg_wr && (reg_addr == A_EVSEL);
    end

    pmu_run_fsm u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (wr_ctrl),
        .ctrl_bit (reg_wdata[0]),
        .run      (run)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inten_q <= '0;
            evsel_q <= '1;
        end else begin
            if (wr_inten) inten_q <= reg_wdata[NUM_CNT-1:0];
            if (wr_evsel) evsel_q <= reg_wdata[EVSEL_W-1:0];
        end
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_slice
        logic cnt_wr_k;
        assign cnt_wr_k = reg_wr && reg_addr[2] && (reg_addr[1:0] == k[1:0]);
        pmu_counter_slice #(
            .W    (CNT_W),
            .SW   (SEL_W),
            .NEVT (NUM_EVT)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .sel      (evsel_q[k*SEL_W +: SEL_W]),
            .evt_vec  (evt_strobe),
            .cnt_wr   (cnt_wr_k),
            .wdata    (reg_wdata),
            .flag_clr (wr_flags && reg_wdata[k]),
            .count    (counts[k]),
            .flag     (flags[k])
        );
    end

    always_comb begin
        irq = |(flags & inten_q);
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[2]) begin
            reg_rdata = counts[reg_addr[1:0]];
        end else begin
            unique case (reg_addr[1:0])
                2'd0: reg_rdata[0]           = run;
                2'd1: reg_rdata[NUM_CNT-1:0] = inten_q;
                2'd2: reg_rdata[NUM_CNT-1:0] = flags;
                2'd3: reg_rdata[EVSEL_W-1:0] = evsel_q;
                default: reg_rdata = '0;
            endcase
        end
    end

    // R4: stopping the unit alone never lowers a pending request
    a_r4_stop_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && wr_ctrl) |=> irq);
    a_r4_inten_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inten && reg_wdata[NUM_CNT-1:0] == '0) |=> !irq);
    a_r10_reset_parked: assert property (@(posedge clk)
        $rose(rst_n) |-> (evsel_q == '1 && flags == '0 && !run));
endmodule

// File: tb/event_perf_monitor_bench.sv
module event_perf_monitor_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [255:0] evt_strobe = '0;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    event_perf_monitor u_event_perf_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .evt_strobe (evt_strobe),
        .irq        (irq)
    );

    typedef struct packed {
        logic [1:0]  cnt;
        logic [7:0]  code;
        logic [7:0]  line;
        logic [7:0]  pulses;
        logic [31:0] expect_v;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 8'h05, 8'd5,   8'd3, 32'd3},
        '{2'd1, 8'h10, 8'd16,  8'd4, 32'd4},
        '{2'd2, 8'h10, 8'd17,  8'd4, 32'd0},
        '{2'd3, 8'hFE, 8'd254, 8'd2, 32'd2},
        '{2'd0, 8'h00, 8'd0,   8'd5, 32'd5},
        '{2'd2, 8'hFF, 8'd255, 8'd3, 32'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input int line, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            evt_strobe = '0;
            evt_strobe[line] = 1'b1;
        end
        @(negedge clk);
        evt_strobe = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(3'd0, v); check("R10 ctrl", v, 32'd0);
        rd(3'd1, v); check("R10 inten", v, 32'd0);
        rd(3'd2, v); check("R10 flags", v, 32'd0);
        rd(3'd3, v); check("R10 evsel", v, 32'hFFFF_FFFF);
        rd(3'd5, v); check("R10 cnt1", v, 32'd0);
        check("R10 irq", {31'd0, irq}, 32'd0);

        // R1 R2 R5 table
        foreach (VECS[i]) begin
            logic [31:0] sel;
            sel = 32'hFFFF_FFFF;
            sel[VECS[i].cnt*8 +: 8] = VECS[i].code;
            wr(3'd0, 32'd0);
            wr(3'd3, sel);
            wr({1'b1, VECS[i].cnt}, 32'd0);
            wr(3'd0, 32'd1);
            pulse(int'(VECS[i].line), int'(VECS[i].pulses));
            wr(3'd0, 32'd0);
            rd({1'b1, VECS[i].cnt}, v);
            check("R1/R2/R5 table", v, VECS[i].expect_v);
        end

        // R11 run bit readback
        wr(3'd0, 32'd1); rd(3'd0, v); check("R11 run set", v, 32'd1);
        wr(3'd0, 32'd0); rd(3'd0, v); check("R11 run clear", v, 32'd0);

        // R3 overflow and continue
        wr(3'd3, 32'hFFFF_FF03);
        wr(3'd4, 32'hFFFF_FFFE);
        wr(3'd1, 32'd1);
        wr(3'd0, 32'd1);
        pulse(3, 1);
        rd(3'd4, v); check("R3 pre-wrap", v, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R3 no flag yet", v, 32'd0);
        pulse(3, 1);
        rd(3'd4, v); check("R3 wrapped", v, 32'd0);
        rd(3'd2, v); check("R3 flag set", v, 32'd1);
        check("R4 irq up", {31'd0, irq}, 32'd1);
        pulse(3, 2);
        rd(3'd4, v); check("R3 keeps counting", v, 32'd2);

        // R4 stop keeps irq
        wr(3'd0, 32'd0);
        check("R4 irq after stop", {31'd0, irq}, 32'd1);
        // R7 write zero no effect
        wr(3'd2, 32'd0); rd(3'd2, v); check("R7 zero write", v, 32'd1);
        // R4 enable clear
        wr(3'd1, 32'd0);
        check("R4 irq masked", {31'd0, irq}, 32'd0);
        rd(3'd2, v); check("R4 flag kept", v, 32'd1);
        wr(3'd1, 32'd1);
        check("R4 irq back", {31'd0, irq}, 32'd1);
        // R7 clear
        wr(3'd2, 32'd1); rd(3'd2, v); check("R7 cleared", v, 32'd0);
        check("R7 irq low", {31'd0, irq}, 32'd0);

        // R6 halted ignores events
        pulse(3, 3);
        rd(3'd4, v); check("R6 halted hold", v, 32'd2);

        // R8 write beats event
        wr(3'd0, 32'd1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'd100; evt_strobe[3] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_strobe = '0;
        rd(3'd4, v); check("R8 write priority", v, 32'd100);

        // R9 overflow beats clear
        wr(3'd4, 32'hFFFF_FFFF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'd1; evt_strobe[3] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_strobe = '0;
        rd(3'd2, v); check("R9 flag survives", v, 32'd1);
        rd(3'd4, v); check("R9 counter wrapped", v, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule